// File: doc/BRIEF.md
# Two-Bank Graphics RAM Command Monitor

This block watches the command pins of a two-bank synchronous graphics RAM on every rising clock edge. It turns each sampled pin pattern into a named command and follows the state of each bank through its lifecycle. That lifecycle covers idle, row opening, open row, read burst, write burst, write recovery, precharge, refresh, and register load. When a command breaks the rules for the current state or comes too early, the block raises a one-cycle error flag with a reason code and then ignores the command. Minimum cycle spacings are elaboration-time integer parameters.

The block is meant to sit beside a memory controller, in a bench or in silicon, as a protocol watchdog. It drives nothing onto the memory bus. Four strobes (row, column, write, special function) form the command code. The bank-select input picks the target bank. The option input asks for auto-precharge on a column command, or for both banks on a precharge. The clock-enable input separates auto-refresh from self-refresh entry, and it also controls self-refresh exit.

Top module: `sgram_cmd_monitor`

## Requirements
- R1: With chip select low, the code {row_strobe_n, col_strobe_n, wr_en_n, special_fn} decodes as follows. 0110 is activate (cmd 2) and 0111 is masked activate (3). 1010 is read (4), 1000 is write (5) and 1001 is block write (6). 0100 is precharge (7), 1100 is burst stop (8) and 1110 is no-op (1). 0000 is mode register load (9) and 0001 is special register load (10). 0010 is auto-refresh (11) when clk_en is high and self-refresh entry (12) when clk_en is low.
- R2: With chip select high, the cycle decodes as deselect (cmd 0) and never raises an error.
- R3: An activate moves the selected bank from idle (state 0) to opening (1), and then to open (2) so that a column command is legal T_RCD cycles after the activate. A column command or precharge aimed at an opening bank gives reason 2 (spacing).
- R4: An activate aimed at an open bank gives reason 1 (bank state), and the bank stays as it was.
- R5: A read or write puts an open bank in read (3) or write (4) for BURST_LEN cycles, counting the command cycle, and then returns it to open. A burst stop ends the burst at once.
- R6: A read with the option bit high leads to precharging (6) and then to idle. Any command to that bank while its burst runs gives reason 1.
- R7: Precharge with the option bit high closes both banks, which stay precharging (6) for T_RP cycles. An activate to a precharging bank gives reason 2.
- R8: Mode load, special load, auto-refresh and self-refresh entry give reason 3 unless both banks are idle.
- R9: After a mode or special register load, both banks show state 8 for T_RSC cycles. Any command other than no-op or deselect in that window gives reason 2.
- R10: Auto-refresh puts both banks in refresh (7). For the next T_RC-1 cycles only no-op or deselect is legal, with reason 2 otherwise.
- R11: While self-refresh holds and clk_en stays low, the decoded command is 14 and no error is raised. From the cycle clk_en returns high, a command other than no-op or deselect gives reason 2 for T_RC cycles.
- R12: The codes 0011, 0101, 1011, 1101 and 1111 decode as undefined (cmd 13) and give reason 4.
- R13: After reset both banks are idle, the command output is 0 and no error is flagged.
- R14: A write with the option bit high passes through write recovery (5) for T_WR-1 cycles and then through precharging to idle. A command to that bank during recovery gives reason 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select, low selects |
| row_strobe_n | input | 1 | Row strobe, command bit 3 |
| col_strobe_n | input | 1 | Column strobe, command bit 2 |
| wr_en_n | input | 1 | Write enable, command bit 1 |
| special_fn | input | 1 | Special-function strobe, command bit 0 |
| clk_en | input | 1 | Clock enable; refresh kind and self-refresh exit |
| bank_sel | input | 1 | Target bank |
| addr_opt | input | 1 | Auto-precharge or precharge-both option |
| cmd_o | output | 4 | Decoded command of the previous cycle |
| bank0_state | output | 4 | State of bank 0 |
| bank1_state | output | 4 | State of bank 1 |
| err_o | output | 1 | One-cycle error pulse |
| err_reason | output | 3 | 0 none, 1 bank state, 2 spacing, 3 banks not idle, 4 undefined |

## Verification
Each output is registered, so the command, error and bank state for pins presented in cycle k appear just after the edge that ends cycle k. The bench changes the pins on the falling edge and reads the results on the next falling edge. Bank countdowns load T-1 (T_RSC for the register-load window) on the command edge and move on when they reach one. Each expected state change is therefore checked on the exact step where it is due, and again one step earlier to show the bank has not yet moved.

// File: rtl/sgram_mon_pkg.sv
package sgram_mon_pkg;

    localparam int NUM_BANKS = 2;

    typedef enum logic [3:0] {
        CMD_DESEL   = 4'd0,
        CMD_NOP     = 4'd1,
        CMD_ACT     = 4'd2,
        CMD_ACT_MSK = 4'd3,
        CMD_READ    = 4'd4,
        CMD_WRITE   = 4'd5,
        CMD_BLKWR   = 4'd6,
        CMD_PRE     = 4'd7,
        CMD_STOP    = 4'd8,
        CMD_MODEREG = 4'd9,
        CMD_SPECREG = 4'd10,
        CMD_AUTOREF = 4'd11,
        CMD_SELFREF = 4'd12,
        CMD_UNDEF   = 4'd13,
        CMD_HOLD    = 4'd14
    } cmd_e;

    typedef enum logic [3:0] {
        BS_IDLE     = 4'd0,
        BS_OPENING  = 4'd1,
        BS_OPEN     = 4'd2,
        BS_READING  = 4'd3,
        BS_WRITING  = 4'd4,
        BS_WRECOV   = 4'd5,
        BS_CLOSING  = 4'd6,
        BS_REFRESH  = 4'd7,
        BS_REGLOAD  = 4'd8
    } bank_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_STATE    = 3'd1,
        ERR_SPACING  = 3'd2,
        ERR_NOT_IDLE = 3'd3,
        ERR_UNDEF    = 3'd4
    } reason_e;

    typedef struct packed {
        cmd_e op;
        logic bank;
        logic opt;
    } cmd_t;

    function automatic cmd_e decode_pins(input logic sel_n, input logic [3:0] code,
                                         input logic ck);
        cmd_e r;
        if (sel_n) begin
            r = CMD_DESEL;
        end else begin
            case (code)
                4'b0110: r = CMD_ACT;
                4'b0111: r = CMD_ACT_MSK;
                4'b1010: r = CMD_READ;
                4'b1000: r = CMD_WRITE;
                4'b1001: r = CMD_BLKWR;
                4'b0100: r = CMD_PRE;
                4'b1100: r = CMD_STOP;
                4'b1110: r = CMD_NOP;
                4'b0000: r = CMD_MODEREG;
                4'b0001: r = CMD_SPECREG;
                4'b0010: r = ck ? CMD_AUTOREF : CMD_SELFREF;
                default: r = CMD_UNDEF;
            endcase
        end
        return r;
    endfunction

    function automatic logic is_quiet(input cmd_e op);
        return (op == CMD_NOP) || (op == CMD_DESEL);
    endfunction

    function automatic logic is_column(input cmd_e op);
        return (op == CMD_READ) || (op == CMD_WRITE) || (op == CMD_BLKWR);
    endfunction

    function automatic logic is_bank_op(input cmd_e op);
        return is_column(op) || (op == CMD_ACT) || (op == CMD_ACT_MSK) || (op == CMD_PRE);
    endfunction

    function automatic logic is_setup(input cmd_e op);
        return (op == CMD_MODEREG) || (op == CMD_SPECREG) ||
               (op == CMD_AUTOREF) || (op == CMD_SELFREF);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
    import sgram_mon_pkg::*;
(
    input  logic chip_sel_n,
    input  logic row_strobe_n,
    input  logic col_strobe_n,
    input  logic wr_en_n,
    input  logic special_fn,
    input  logic clk_en,
    input  logic bank_sel,
    input  logic addr_opt,
    input  logic sr_active,
    output cmd_t cmd
);
    always_comb begin
        if (sr_active && !clk_en) begin
            cmd.op = CMD_HOLD;
        end else begin
            cmd.op = decode_pins(chip_sel_n,
                                 {row_strobe_n, col_strobe_n, wr_en_n, special_fn},
                                 clk_en);
        end
        cmd.bank = bank_sel;
        cmd.opt  = addr_opt;
    end
endmodule

// File: rtl/sgram_bank_fsm.sv
module sgram_bank_fsm
    import sgram_mon_pkg::*;
#(
    parameter int BANK_ID   = 0,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int T_RC      = 5,
    parameter int T_RSC     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  cmd_t    cmd,
    input  logic    accept,
    input  logic    start_refresh,
    input  logic    hold_refresh,
    input  logic    start_regset,
    output bank_e   state,
    output reason_e chk
);
    localparam int MAXT = max2(max2(max2(T_RCD, T_RP), max2(T_WR, T_RC)),
                               max2(T_RSC, BURST_LEN));
    localparam int CW = $clog2(MAXT + 1);
    localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_WR  = CW'(T_WR - 1);
    localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] L_RSC = CW'(T_RSC);
    localparam logic [CW-1:0] L_BL  = CW'(BURST_LEN - 1);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] cnt, ncnt;
    logic          ap, nap;
    bank_e         nstate;
    logic          hits, burst, timed;

    always_comb begin
        hits  = is_bank_op(cmd.op) &&
                ((cmd.bank == 1'(BANK_ID)) || (cmd.op == CMD_PRE && cmd.opt));
        burst = (state == BS_READING) || (state == BS_WRITING);
        timed = (state != BS_IDLE) && (state != BS_OPEN);
    end

    // legality of the current command for this bank
    always_comb begin
        chk = ERR_NONE;
        case (state)
            BS_IDLE: begin
                if (hits && is_column(cmd.op)) chk = ERR_STATE;
            end
            BS_OPENING: begin
                if (hits && (is_column(cmd.op) || cmd.op == CMD_PRE)) chk = ERR_SPACING;
                else if (hits) chk = ERR_STATE;
            end
            BS_OPEN: begin
                if (hits && (cmd.op == CMD_ACT || cmd.op == CMD_ACT_MSK)) chk = ERR_STATE;
            end
            BS_READING, BS_WRITING: begin
                if (ap && (hits || cmd.op == CMD_STOP)) chk = ERR_STATE;
                else if (hits && (cmd.op == CMD_ACT || cmd.op == CMD_ACT_MSK)) chk = ERR_STATE;
            end
            BS_WRECOV: begin
                if (hits) chk = ERR_STATE;
            end
            BS_CLOSING: begin
                if (hits && (cmd.op == CMD_ACT || cmd.op == CMD_ACT_MSK)) chk = ERR_SPACING;
                else if (hits && is_column(cmd.op)) chk = ERR_STATE;
            end
            default: chk = ERR_NONE;
        endcase
    end

    // next state: countdown first, accepted commands override
    always_comb begin
        nstate = state;
        ncnt   = cnt;
        nap    = ap;
        if (timed) begin
            if (cnt > ONE) begin
                ncnt = cnt - ONE;
            end else begin
                nap = 1'b0;
                case (state)
                    BS_OPENING: nstate = BS_OPEN;
                    BS_READING: begin
                        nstate = ap ? BS_CLOSING : BS_OPEN;
                        ncnt   = L_RP;
                    end
                    BS_WRITING: begin
                        nstate = ap ? BS_WRECOV : BS_OPEN;
                        ncnt   = L_WR;
                    end
                    BS_WRECOV: begin
                        nstate = BS_CLOSING;
                        ncnt   = L_RP;
                    end
                    default: nstate = BS_IDLE;
                endcase
            end
        end
        if (accept && hits) begin
            case (cmd.op)
                CMD_ACT, CMD_ACT_MSK: begin
                    nstate = BS_OPENING;
                    ncnt   = L_RCD;
                end
                CMD_READ: begin
                    nstate = BS_READING;
                    ncnt   = L_BL;
                    nap    = cmd.opt;
                end
                CMD_WRITE: begin
                    nstate = BS_WRITING;
                    ncnt   = L_BL;
                    nap    = cmd.opt;
                end
                CMD_BLKWR: begin
                    nstate = cmd.opt ? BS_WRECOV : BS_OPEN;
                    ncnt   = L_WR;
                    nap    = 1'b0;
                end
                CMD_PRE: begin
                    if (state == BS_OPEN || burst) begin
                        nstate = BS_CLOSING;
                        ncnt   = L_RP;
                        nap    = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (accept && cmd.op == CMD_STOP && burst) begin
            nstate = BS_OPEN;
            nap    = 1'b0;
        end
        if (start_regset) begin
            nstate = BS_REGLOAD;
            ncnt   = L_RSC;
            nap    = 1'b0;
        end
        if (start_refresh || hold_refresh) begin
            nstate = BS_REFRESH;
            ncnt   = L_RC;
            nap    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BS_IDLE;
            cnt   <= '0;
            ap    <= 1'b0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
            ap    <= nap;
        end
    end

    // R3: an opening bank can only finish opening
    assert_open_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (state == BS_OPENING && !start_refresh && !hold_refresh)
        |=> (state == BS_OPENING || state == BS_OPEN));

    // R6: an auto-closing read never returns to the open state
    assert_ap_path_R6: assert property (@(posedge clk) disable iff (rst)
        (state == BS_READING && ap) |=> (state == BS_READING || state == BS_CLOSING));

    // R7: a closing bank only goes on to idle
    assert_close_path_R7: assert property (@(posedge clk) disable iff (rst)
        (state == BS_CLOSING) |=> (state == BS_CLOSING || state == BS_IDLE));

endmodule

// File: rtl/sgram_cmd_monitor.sv
module sgram_cmd_monitor
    import sgram_mon_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int T_RC      = 5,
    parameter int T_RSC     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chip_sel_n,
    input  logic       row_strobe_n,
    input  logic       col_strobe_n,
    input  logic       wr_en_n,
    input  logic       special_fn,
    input  logic       clk_en,
    input  logic       bank_sel,
    input  logic       addr_opt,
    output logic [3:0] cmd_o,
    output logic [3:0] bank0_state,
    output logic [3:0] bank1_state,
    output logic       err_o,
    output logic [2:0] err_reason
);
    cmd_t    cmd_d;
    bank_e   st  [NUM_BANKS];
    reason_e chk [NUM_BANKS];
    reason_e reason, bank_r;
    logic    sr_active, exit_sr, hold_sr;
    logic    all_idle, locked, accept;
    logic    start_ref, hold_ref, start_rs;
    cmd_e    cmd_q;
    reason_e reason_q;
    logic    err_q;

    sgram_cmd_decode u_decode (
        .chip_sel_n  (chip_sel_n),
        .row_strobe_n(row_strobe_n),
        .col_strobe_n(col_strobe_n),
        .wr_en_n     (wr_en_n),
        .special_fn  (special_fn),
        .clk_en      (clk_en),
        .bank_sel    (bank_sel),
        .addr_opt    (addr_opt),
        .sr_active   (sr_active),
        .cmd         (cmd_d)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sgram_bank_fsm #(
            .BANK_ID  (b),
            .T_RCD    (T_RCD),
            .T_RP     (T_RP),
            .T_WR     (T_WR),
            .T_RC     (T_RC),
            .T_RSC    (T_RSC),
            .BURST_LEN(BURST_LEN)
        ) u_bank (
            .clk          (clk),
            .rst          (rst),
            .cmd          (cmd_d),
            .accept       (accept),
            .start_refresh(start_ref),
            .hold_refresh (hold_ref),
            .start_regset (start_rs),
            .state        (st[b]),
            .chk          (chk[b])
        );
    end

    always_comb begin
        all_idle = 1'b1;
        locked   = 1'b0;
        bank_r   = ERR_NONE;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (st[b] != BS_IDLE) all_idle = 1'b0;
            if (st[b] == BS_REFRESH || st[b] == BS_REGLOAD) locked = 1'b1;
            if (bank_r == ERR_NONE) bank_r = chk[b];
        end
    end

    // error arbitration: code, lockout window, idle rule, then per-bank rules
    always_comb begin
        exit_sr = sr_active && clk_en;
        hold_sr = sr_active && !clk_en;
        if (hold_sr) begin
            reason = ERR_NONE;
        end else if (cmd_d.op == CMD_UNDEF) begin
            reason = ERR_UNDEF;
        end else if ((locked || exit_sr) && !is_quiet(cmd_d.op)) begin
            reason = ERR_SPACING;
        end else if (is_setup(cmd_d.op) && !all_idle) begin
            reason = ERR_NOT_IDLE;
        end else begin
            reason = bank_r;
        end
        accept    = (reason == ERR_NONE) && !sr_active;
        start_ref = exit_sr || (accept && cmd_d.op == CMD_AUTOREF);
        hold_ref  = hold_sr || (accept && cmd_d.op == CMD_SELFREF);
        start_rs  = accept && (cmd_d.op == CMD_MODEREG || cmd_d.op == CMD_SPECREG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_active <= 1'b0;
            cmd_q     <= CMD_DESEL;
            err_q     <= 1'b0;
            reason_q  <= ERR_NONE;
        end else begin
            if (accept && cmd_d.op == CMD_SELFREF) sr_active <= 1'b1;
            else if (exit_sr)                      sr_active <= 1'b0;
            cmd_q    <= cmd_d.op;
            err_q    <= (reason != ERR_NONE);
            reason_q <= reason;
        end
    end

    assign cmd_o       = cmd_q;
    assign err_o       = err_q;
    assign err_reason  = reason_q;
    assign bank0_state = st[0];
    assign bank1_state = st[1];

    // R2: a deselected cycle reports deselect and no error
    assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (chip_sel_n && !sr_active) |=> (cmd_o == CMD_DESEL && !err_o));

    // R11: held self-refresh ignores every pin pattern
    assert_selfref_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (sr_active && !clk_en) |=> (cmd_o == CMD_HOLD && !err_o));

    // R10: refresh always covers both banks together
    assert_refresh_pair_R10: assert property (@(posedge clk) disable iff (rst)
        (st[0] == BS_REFRESH) |-> (st[1] == BS_REFRESH));

    // R9: a non-quiet command inside the register-load window is flagged
    assert_regload_lock_R9: assert property (@(posedge clk) disable iff (rst)
        (st[0] == BS_REGLOAD && !sr_active && !is_quiet(cmd_d.op)) |=> err_o);

endmodule

// File: tb/test_sgram_cmd_monitor.sv
module test_sgram_cmd_monitor;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] C_ACT   = 4'b0110;
    localparam logic [3:0] C_ACTM  = 4'b0111;
    localparam logic [3:0] C_READ  = 4'b1010;
    localparam logic [3:0] C_WRITE = 4'b1000;
    localparam logic [3:0] C_PRE   = 4'b0100;
    localparam logic [3:0] C_STOP  = 4'b1100;
    localparam logic [3:0] C_NOP   = 4'b1110;
    localparam logic [3:0] C_MODE  = 4'b0000;
    localparam logic [3:0] C_SPEC  = 4'b0001;
    localparam logic [3:0] C_REF   = 4'b0010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_sel_n = 1'b1, row_strobe_n = 1'b1, col_strobe_n = 1'b1;
    logic wr_en_n = 1'b1, special_fn = 1'b0, clk_en = 1'b1;
    logic bank_sel = 1'b0, addr_opt = 1'b0;
    logic [3:0] cmd_o, bank0_state, bank1_state;
    logic       err_o;
    logic [2:0] err_reason;
    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sgram_cmd_monitor i_sgram_cmd_monitor (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .row_strobe_n(row_strobe_n),
        .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n), .special_fn(special_fn),
        .clk_en(clk_en), .bank_sel(bank_sel), .addr_opt(addr_opt), .cmd_o(cmd_o),
        .bank0_state(bank0_state), .bank1_state(bank1_state), .err_o(err_o),
        .err_reason(err_reason)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input int ecmd, input int eb0,
                              input int eb1, input int ereason);
        check(req, "cmd", int'(cmd_o), ecmd);
        check(req, "bank0", int'(bank0_state), eb0);
        check(req, "bank1", int'(bank1_state), eb1);
        check(req, "err", int'(err_o), (ereason != 0) ? 1 : 0);
        check(req, "reason", int'(err_reason), ereason);
    endtask

    task automatic issue(input logic [3:0] code, input logic bank, input logic opt,
                         input logic ck);
        chip_sel_n = 1'b0;
        {row_strobe_n, col_strobe_n, wr_en_n, special_fn} = code;
        bank_sel = bank;
        addr_opt = opt;
        clk_en   = ck;
        @(negedge clk);
    endtask

    task automatic nop();
        issue(C_NOP, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out("R13", 0, 0, 0, 0);
    endtask

    task automatic t_decode();
        nop();
        expect_out("R1", 1, 0, 0, 0);
        chip_sel_n = 1'b1;
        {row_strobe_n, col_strobe_n, wr_en_n, special_fn} = C_ACT;
        @(negedge clk);
        expect_out("R2", 0, 0, 0, 0);
        issue(C_STOP, 1'b0, 1'b0, 1'b1);
        expect_out("R1", 8, 0, 0, 0);
    endtask

    task automatic t_open_and_burst();
        issue(C_ACT, 1'b0, 1'b0, 1'b1);
        expect_out("R3", 2, 1, 0, 0);
        issue(C_READ, 1'b0, 1'b0, 1'b1);
        expect_out("R3", 4, 1, 0, 2);
        nop();
        expect_out("R3", 1, 2, 0, 0);
        issue(C_ACT, 1'b0, 1'b0, 1'b1);
        expect_out("R4", 2, 2, 0, 1);
        issue(C_READ, 1'b0, 1'b0, 1'b1);
        expect_out("R5", 4, 3, 0, 0);
        nop();
        nop();
        expect_out("R5", 1, 3, 0, 0);
        nop();
        expect_out("R5", 1, 2, 0, 0);
        issue(C_WRITE, 1'b0, 1'b0, 1'b1);
        expect_out("R5", 5, 4, 0, 0);
        issue(C_STOP, 1'b0, 1'b0, 1'b1);
        expect_out("R5", 8, 2, 0, 0);
        issue(C_ACTM, 1'b1, 1'b0, 1'b1);
        expect_out("R1", 3, 2, 1, 0);
        issue(C_MODE, 1'b0, 1'b0, 1'b1);
        expect_out("R8", 9, 2, 1, 3);
        issue(C_PRE, 1'b0, 1'b1, 1'b1);
        expect_out("R3", 7, 2, 2, 2);
        issue(C_PRE, 1'b0, 1'b1, 1'b1);
        expect_out("R7", 7, 6, 6, 0);
        issue(C_ACT, 1'b0, 1'b0, 1'b1);
        expect_out("R7", 2, 6, 6, 2);
        nop();
        expect_out("R7", 1, 0, 0, 0);
    endtask

    task automatic t_auto_read();
        issue(C_ACT, 1'b0, 1'b0, 1'b1);
        nop();
        nop();
        issue(C_READ, 1'b0, 1'b1, 1'b1);
        expect_out("R6", 4, 3, 0, 0);
        issue(C_WRITE, 1'b0, 1'b0, 1'b1);
        expect_out("R6", 5, 3, 0, 1);
        nop();
        nop();
        expect_out("R6", 1, 6, 0, 0);
        nop();
        nop();
        expect_out("R6", 1, 0, 0, 0);
    endtask

    task automatic t_auto_write();
        issue(C_ACT, 1'b1, 1'b0, 1'b1);
        nop();
        nop();
        issue(C_WRITE, 1'b1, 1'b1, 1'b1);
        expect_out("R14", 5, 0, 4, 0);
        nop();
        nop();
        nop();
        expect_out("R14", 1, 0, 5, 0);
        issue(C_PRE, 1'b1, 1'b0, 1'b1);
        expect_out("R14", 7, 0, 6, 1);
        nop();
        nop();
        expect_out("R14", 1, 0, 0, 0);
    endtask

    task automatic t_regload_undef();
        issue(C_MODE, 1'b0, 1'b0, 1'b1);
        expect_out("R9", 9, 8, 8, 0);
        issue(C_ACT, 1'b0, 1'b0, 1'b1);
        expect_out("R9", 2, 8, 8, 2);
        nop();
        expect_out("R9", 1, 0, 0, 0);
        issue(C_SPEC, 1'b0, 1'b0, 1'b1);
        expect_out("R9", 10, 8, 8, 0);
        nop();
        nop();
        issue(4'b0011, 1'b0, 1'b0, 1'b1);
        expect_out("R12", 13, 0, 0, 4);
        issue(4'b1101, 1'b0, 1'b0, 1'b1);
        expect_out("R12", 13, 0, 0, 4);
    endtask

    task automatic t_refresh();
        issue(C_REF, 1'b0, 1'b0, 1'b1);
        expect_out("R10", 11, 7, 7, 0);
        issue(C_READ, 1'b0, 1'b0, 1'b1);
        expect_out("R10", 4, 7, 7, 2);
        nop();
        nop();
        expect_out("R10", 1, 7, 7, 0);
        nop();
        expect_out("R10", 1, 0, 0, 0);
    endtask

    task automatic t_selfrefresh();
        issue(C_REF, 1'b0, 1'b0, 1'b0);
        expect_out("R1", 12, 7, 7, 0);
        for (int i = 0; i < 3; i++) begin
            issue(C_ACT, 1'b0, 1'b0, 1'b0);
            expect_out("R11", 14, 7, 7, 0);
        end
        issue(C_ACT, 1'b0, 1'b0, 1'b1);
        expect_out("R11", 2, 7, 7, 2);
        nop();
        nop();
        nop();
        expect_out("R11", 1, 7, 7, 0);
        nop();
        expect_out("R11", 1, 0, 0, 0);
        issue(C_ACT, 1'b0, 1'b0, 1'b1);
        issue(C_REF, 1'b0, 1'b0, 1'b1);
        expect_out("R8", 11, 1, 0, 3);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog all requirements: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_decode();
        t_open_and_burst();
        t_auto_read();
        t_auto_write();
        t_regload_undef();
        t_refresh();
        t_selfrefresh();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule